// File: doc/BRIEF.md
# Two-Way Doorbell Interrupt Controller

This block passes software doorbells between an application processor and a network processor. It holds two independent sets of doorbell state, one for each direction. Direction 0 carries doorbells from the application side to the network side and drives `irq[0]`. Direction 1 carries doorbells from the network side to the application side and drives `irq[1]`. Each set has 32 channels. A sender rings a channel by writing a 1 to its trigger register. The receiver masks channels, reads pending doorbells, and retires them through either a status-clear register or an acknowledge register.

Both processors have their own register port, made of a word address, a write strobe, write data and combinational read data. Either port can reach both direction sets. Two writes that land on the same set in the same cycle are merged, using the priorities given below. Each level interrupt output is a registered OR of the channels that are pending and not masked.

Top module: `ipi_doorbell`

## Requirements
- R1: In the cycle after a synchronous reset, every raw status bit reads 0, every mask bit reads 1 (all channels disabled) and both `irq` outputs are 0.
- R2: A write to the direct mask register (index 0) replaces the whole mask of that set. If both ports write the direct mask of the same set in the same cycle, the value from port 0 is taken.
- R3: A 1 written to the mask-set alias (index 1) sets that mask bit, and a 1 written to the mask-clear alias (index 2) clears it. A 0 written to either alias leaves the bit unchanged. A mask-set and a mask-clear on the same bit in the same cycle leave the bit set. A direct mask write overrides both aliases in the same cycle. Reads of indices 0, 1 and 2 all return the mask.
- R4: A 1 written to the trigger register (index 5) sets that raw status bit, and a 0 has no effect. The trigger register always reads 0.
- R5: A 1 written to the status-clear register (index 3) or to the acknowledge register (index 4) clears that raw status bit. Both registers read 0.
- R6: A trigger on a channel in the same cycle as a status-clear or acknowledge write to that channel leaves the raw bit set.
- R7: The masked status register (index 6) reads raw AND NOT mask. The raw status register (index 7) reads the raw bits. Reading either one changes no state.
- R8: `irq[d]` is 1 in the cycle after the masked status of set d is nonzero, and 0 in the cycle after it is zero.
- R9: Address bit 3 selects the set and bits 2:0 select the register index. A write to one set never changes the state or the interrupt of the other set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 2x4 | Word address per port: bit 3 selects the set, bits 2:0 the register index |
| bus_we | input | 2 | Write strobe per port |
| bus_wdata | input | 2x32 | Write data per port |
| bus_rdata | output | 2x32 | Combinational read data per port |
| irq | output | 2 | Level interrupt per direction: bit 0 to the network side, bit 1 to the application side |

## Verification
A corrupted mask or raw bit shows up on the masked and raw readback in the same cycle that the bad write lands. One cycle later it shows up on the matching `irq` line. A merge error between the two ports shows up when both ports write the same set in one cycle, for example a lost doorbell, the wrong direct mask value winning, or a clear that beats a trigger. A leak between the sets shows up as a changed readback or a change on the other `irq` line. The bench reads through both ports on every clock, so each of these faults is seen within one or two cycles of its cause.

// File: rtl/ipi_pkg.sv
package ipi_pkg;
    localparam int NCH    = 32;
    localparam int NPORT  = 2;
    localparam int NDIR   = 2;
    localparam int IDX_W  = 3;
    localparam int ADDR_W = IDX_W + 1;

    typedef enum logic [IDX_W-1:0] {
        RG_MASK     = 3'd0,
        RG_MASK_SET = 3'd1,
        RG_MASK_CLR = 3'd2,
        RG_STS_CLR  = 3'd3,
        RG_ACK      = 3'd4,
        RG_TRIG     = 3'd5,
        RG_MASKED   = 3'd6,
        RG_RAW      = 3'd7
    } reg_idx_t;

    typedef struct packed {
        logic           mask_wr;
        logic [NCH-1:0] mask_val;
        logic [NCH-1:0] mask_set;
        logic [NCH-1:0] mask_clr;
        logic [NCH-1:0] sts_clr;
        logic [NCH-1:0] trig;
    } wr_req_t;

    function automatic reg_idx_t idx_of(input logic [ADDR_W-1:0] a);
        return reg_idx_t'(a[IDX_W-1:0]);
    endfunction

    function automatic logic dir_of(input logic [ADDR_W-1:0] a);
        return a[ADDR_W-1];
    endfunction
endpackage

// File: rtl/ipi_decode.sv
module ipi_decode
    import ipi_pkg::*;
#(
    parameter logic DIR = 1'b0
) (
    input  logic [NPORT-1:0][ADDR_W-1:0] addr,
    input  logic [NPORT-1:0]             we,
    input  logic [NPORT-1:0][NCH-1:0]    wdata,
    output wr_req_t                      req
);
    // Ports are walked from the highest index down, so port 0 ends up
    // holding a direct mask write when more than one port makes one.
    always_comb begin
        req = '0;
        for (int p = NPORT - 1; p >= 0; p--) begin
            if (we[p] && (dir_of(addr[p]) == DIR)) begin
                case (idx_of(addr[p]))
                    RG_MASK: begin
                        req.mask_wr  = 1'b1;
                        req.mask_val = wdata[p];
                    end
                    RG_MASK_SET: req.mask_set = req.mask_set | wdata[p];
                    RG_MASK_CLR: req.mask_clr = req.mask_clr | wdata[p];
                    RG_STS_CLR,
                    RG_ACK:      req.sts_clr  = req.sts_clr | wdata[p];
                    RG_TRIG:     req.trig     = req.trig | wdata[p];
                    default: ;
                endcase
            end
        end
    end
endmodule

// File: rtl/ipi_mask_reg.sv
module ipi_mask_reg
    import ipi_pkg::*;
(
    input  logic           clk,
    input  logic           rst,
    input  logic           wr_en,
    input  logic [NCH-1:0] wr_val,
    input  logic [NCH-1:0] set_bits,
    input  logic [NCH-1:0] clr_bits,
    output logic [NCH-1:0] mask
);
    always_ff @(posedge clk) begin
        if (rst)
            mask <= '1;
        else if (wr_en)
            mask <= wr_val;
        else
            mask <= (mask & ~clr_bits) | set_bits;
    end

    p_direct_r2: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> mask == $past(wr_val));
    p_set_wins_r3: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> (mask & $past(set_bits)) == $past(set_bits));
    p_clr_r3: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> (mask & $past(clr_bits & ~set_bits)) == '0);
    p_keep_r3: assert property (@(posedge clk) disable iff (rst)
        !wr_en && set_bits == '0 && clr_bits == '0 |=> $stable(mask));
endmodule

// File: rtl/ipi_status_reg.sv
module ipi_status_reg
    import ipi_pkg::*;
(
    input  logic           clk,
    input  logic           rst,
    input  logic [NCH-1:0] trig,
    input  logic [NCH-1:0] clr,
    input  logic [NCH-1:0] mask,
    output logic [NCH-1:0] raw,
    output logic [NCH-1:0] masked,
    output logic           irq
);
    assign masked = raw & ~mask;

    always_ff @(posedge clk) begin
        if (rst) begin
            raw <= '0;
            irq <= 1'b0;
        end else begin
            raw <= (raw & ~clr) | trig;
            irq <= |masked;
        end
    end

    p_trig_keep_r6: assert property (@(posedge clk) disable iff (rst)
        trig != '0 |=> (raw & $past(trig)) == $past(trig));
    p_clear_r5: assert property (@(posedge clk) disable iff (rst)
        clr != '0 |=> (raw & $past(clr & ~trig)) == '0);
    p_no_spont_r4: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (raw & ~$past(raw) & ~$past(trig)) == '0);
    p_irq_rise_r8: assert property (@(posedge clk) disable iff (rst)
        (raw & ~mask) != '0 |=> irq);
    p_irq_fall_r8: assert property (@(posedge clk) disable iff (rst)
        (raw & ~mask) == '0 |=> !irq);
endmodule

// File: rtl/ipi_doorbell.sv
module ipi_doorbell
    import ipi_pkg::*;
(
    input  logic                         clk,
    input  logic                         rst,
    input  logic [NPORT-1:0][ADDR_W-1:0] bus_addr,
    input  logic [NPORT-1:0]             bus_we,
    input  logic [NPORT-1:0][NCH-1:0]    bus_wdata,
    output logic [NPORT-1:0][NCH-1:0]    bus_rdata,
    output logic [NDIR-1:0]              irq
);
    logic [NDIR-1:0][NCH-1:0] mask_v;
    logic [NDIR-1:0][NCH-1:0] raw_v;
    logic [NDIR-1:0][NCH-1:0] masked_v;

    for (genvar d = 0; d < NDIR; d++) begin : g_dir
        wr_req_t req;

        ipi_decode #(.DIR(1'(d))) u_dec (
            .addr  (bus_addr),
            .we    (bus_we),
            .wdata (bus_wdata),
            .req   (req)
        );

        ipi_mask_reg u_mask (
            .clk      (clk),
            .rst      (rst),
            .wr_en    (req.mask_wr),
            .wr_val   (req.mask_val),
            .set_bits (req.mask_set),
            .clr_bits (req.mask_clr),
            .mask     (mask_v[d])
        );

        ipi_status_reg u_sts (
            .clk    (clk),
            .rst    (rst),
            .trig   (req.trig),
            .clr    (req.sts_clr),
            .mask   (mask_v[d]),
            .raw    (raw_v[d]),
            .masked (masked_v[d]),
            .irq    (irq[d])
        );
    end

    always_comb begin
        for (int p = 0; p < NPORT; p++) begin
            case (idx_of(bus_addr[p]))
                RG_MASK, RG_MASK_SET, RG_MASK_CLR:
                    bus_rdata[p] = mask_v[dir_of(bus_addr[p])];
                RG_MASKED: bus_rdata[p] = masked_v[dir_of(bus_addr[p])];
                RG_RAW:    bus_rdata[p] = raw_v[dir_of(bus_addr[p])];
                default:   bus_rdata[p] = '0;
            endcase
        end
    end

    p_reset_r1: assert property (@(posedge clk)
        $past(rst) |-> (mask_v == '1 && raw_v == '0 && irq == '0));
    p_isolate_r9: assert property (@(posedge clk) disable iff (rst)
        (bus_we == '0) |=> $stable(mask_v) && (raw_v == $past(raw_v)));
endmodule

// File: tb/tb_ipi_doorbell.sv
module tb_ipi_doorbell;
    import ipi_pkg::*;

    localparam int CLK_P = 10;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [NPORT-1:0][ADDR_W-1:0] bus_addr = '0;
    logic [NPORT-1:0]             bus_we = '0;
    logic [NPORT-1:0][NCH-1:0]    bus_wdata = '0;
    logic [NPORT-1:0][NCH-1:0]    bus_rdata;
    logic [NDIR-1:0]              irq;

    int checks = 0;
    int fails  = 0;

    logic [NCH-1:0] m_mask [NDIR];
    logic [NCH-1:0] m_raw  [NDIR];
    logic [NDIR-1:0] m_irq;

    always #(CLK_P/2) clk = ~clk;

    ipi_doorbell dut (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
    );

    function automatic logic [NCH-1:0] ref_read(input logic [ADDR_W-1:0] a);
        int s = int'(a[3]);
        case (a[2:0])
            3'd0, 3'd1, 3'd2: return m_mask[s];
            3'd6: return m_raw[s] & ~m_mask[s];
            3'd7: return m_raw[s];
            default: return '0;
        endcase
    endfunction

    task automatic chk(input string tag, input logic [NCH-1:0] act, input logic [NCH-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    // Behavioural reference: merges the writes of this cycle as the requirements state.
    task automatic model_update();
        logic [NDIR-1:0] nirq;
        for (int s = 0; s < NDIR; s++) begin
            logic [NCH-1:0] st, cl, sc, tr, dv;
            bit dw;
            st = '0; cl = '0; sc = '0; tr = '0; dv = '0; dw = 0;
            nirq[s] = |(m_raw[s] & ~m_mask[s]);
            for (int p = 0; p < NPORT; p++) begin
                if (bus_we[p] && int'(bus_addr[p][3]) == s) begin
                    case (bus_addr[p][2:0])
                        3'd0: if (!dw) begin dw = 1; dv = bus_wdata[p]; end
                        3'd1: st |= bus_wdata[p];
                        3'd2: cl |= bus_wdata[p];
                        3'd3, 3'd4: sc |= bus_wdata[p];
                        3'd5: tr |= bus_wdata[p];
                        default: ;
                    endcase
                end
            end
            m_mask[s] = dw ? dv : ((m_mask[s] & ~cl) | st);
            m_raw[s]  = (m_raw[s] & ~sc) | tr;
        end
        m_irq = nirq;
    endtask

    task automatic step(input string tag);
        @(posedge clk);
        model_update();
        @(negedge clk);
        chk({tag, " irq"}, NCH'(irq), NCH'(m_irq));
        for (int p = 0; p < NPORT; p++)
            chk({tag, " rdata"}, bus_rdata[p], ref_read(bus_addr[p]));
        bus_we = '0;
    endtask

    task automatic wr(input int p, input logic [ADDR_W-1:0] a, input logic [NCH-1:0] d);
        bus_we[p] = 1'b1; bus_addr[p] = a; bus_wdata[p] = d;
    endtask

    task automatic rd(input int p, input logic [ADDR_W-1:0] a);
        bus_addr[p] = a;
    endtask

    initial begin
        repeat (1000000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        for (int s = 0; s < NDIR; s++) begin m_mask[s] = '1; m_raw[s] = '0; end
        m_irq = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        rd(0, 4'h0); rd(1, 4'h7); #1;
        chk("R1 mask", bus_rdata[0], '1);
        chk("R1 raw", bus_rdata[1], '0);
        chk("R1 irq", NCH'(irq), '0);
        rd(0, 4'h8); rd(1, 4'hF); #1;
        chk("R1 mask s1", bus_rdata[0], '1);
        chk("R1 raw s1", bus_rdata[1], '0);

        // R4 trigger while fully masked, trigger reads 0
        wr(0, 4'h5, 32'h5); rd(1, 4'h7); step("R4");
        rd(0, 4'h5); rd(1, 4'h6); step("R4");
        wr(0, 4'h5, 32'h0); step("R4");
        // R2 direct mask write
        wr(1, 4'h0, 32'hFFFF_FFFA); rd(0, 4'h6); step("R2");
        rd(0, 4'h6); rd(1, 4'h7); step("R8");
        step("R7");
        step("R7");
        // R3 set vs clear on same bit, set wins
        wr(0, 4'h1, 32'h0000_0100); wr(1, 4'h2, 32'h0000_0101); step("R3");
        wr(0, 4'h2, 32'h0000_0000); rd(1, 4'h0); step("R3");
        // R2 both ports direct write, port 0 wins
        wr(0, 4'h0, 32'h0); wr(1, 4'h0, 32'h0000_FFFF); step("R2");
        // R3 direct write beats alias
        wr(0, 4'h1, 32'hF0); wr(1, 4'h0, 32'h1234_5678); step("R3");
        wr(0, 4'h0, 32'h0); rd(1, 4'h6); step("R3");
        // R5 status clear and acknowledge
        wr(0, 4'h3, 32'h1); rd(1, 4'h7); step("R5");
        wr(1, 4'h4, 32'h4); rd(0, 4'h4); step("R5");
        rd(0, 4'h3); step("R8");
        step("R8");
        // R6 trigger meets acknowledge / clear on set 1
        wr(0, 4'h8, 32'h0); step("R6");
        wr(0, 4'hD, 32'h2); wr(1, 4'hC, 32'h2); step("R6");
        wr(1, 4'hD, 32'h8); wr(0, 4'hB, 32'hA); step("R6");
        rd(0, 4'hF); rd(1, 4'h7); step("R9");
        step("R8");
        // R9 writes to set 1 leave set 0 alone
        wr(0, 4'h5, 32'h80); step("R9");
        wr(1, 4'h8, 32'hFFFF_FFFF); rd(0, 4'h6); step("R9");
        wr(1, 4'hC, 32'hFFFF_FFFF); rd(0, 4'h7); step("R9");
        step("R8");
        // Mixed traffic on both ports
        for (int i = 0; i < 400; i++) begin
            for (int p = 0; p < NPORT; p++) begin
                bus_addr[p]  = 4'($urandom);
                bus_we[p]    = 1'($urandom);
                bus_wdata[p] = ($urandom % 3 == 0) ? '1 : NCH'($urandom);
            end
            step("R9");
        end
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule